// File: doc/BRIEF.md
# Descriptor-Checked Memory Access Unit

This block takes an indexed memory request that is addressed through a tagged descriptor word and checks it before it reaches memory. A descriptor is a 51-bit word with these fields:

- a 3-bit type tag;
- a resident flag;
- a reserved field;
- a 20-bit length bound;
- a 20-bit absolute base.

The requester supplies the descriptor, a 20-bit relative index, a read or write command and, for writes, a 51-bit tagged data word. The block then does one of two things. It performs the access at base plus index in its own synchronous word memory, or it reports exactly one fault class and leaves memory alone.

Faults have a fixed priority order. A malformed or wrongly typed word is reported first, then a non-resident target, then an out-of-bounds index. Writing a word that carries the control-word tag counts as a type fault unless the request carries a privilege override. Requests are accepted with a valid/ready handshake. Each accepted request produces either a completion or a fault one cycle later.

Top module: `desc_access_unit`

## Requirements
- R1: While `rst` is high, `req_ready`, `done_valid` and `fault_valid` are low. `req_ready` is high from the first clock edge after `rst` falls.
- R2: A request is accepted when `req_valid` and `req_ready` are both high at a rising edge. At the next edge exactly one of `done_valid` or `fault_valid` goes high for one cycle. With no accepted request, neither goes high.
- R3: Descriptor layout is tag [50:48], resident flag [47], reserved [46:40], length [39:20], base [19:0]. A tag other than 3'b101, or any nonzero reserved bit, raises a type fault, reported as `fault_code` = 3'b100.
- R4: A write whose data word has tag bits [50:48] = 3'b011 (control word) raises a type fault (3'b100) unless `req_priv` is high. With `req_priv` high the write completes and stores the word.
- R5: A resident flag of 0 raises a presence fault, `fault_code` = 3'b010.
- R6: An index strictly greater than the length field raises an index fault, `fault_code` = 3'b001. An index equal to the length is allowed.
- R7: When several faults apply, only the highest-priority one is reported. Type ranks above presence, and presence ranks above index.
- R8: `done_addr` reports the physical address, which is the sum of base and index truncated to 20 bits, so it wraps past 20'hFFFFF.
- R9: The memory is addressed by the low `MEM_AW` bits of the physical address. A completed read returns on `done_rdata` the last word written to that location.
- R10: A completed write returns on `done_rdata` the word that location held before the write.
- R11: A request that faults leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | Privilege override for control-word stores |
| req_desc | input | 51 | Descriptor word |
| req_index | input | 20 | Relative index |
| req_wdata | input | 51 | Tagged word to store |
| done_valid | output | 1 | Access completed this cycle |
| done_addr | output | 20 | Physical address of the completed access |
| done_rdata | output | 51 | Read data, or the prior contents on a write |
| fault_valid | output | 1 | Request faulted this cycle |
| fault_code | output | 3 | One-hot fault: [2] type, [1] presence, [0] index |

## Verification
The assertions assume that `req_desc`, `req_index`, `req_write` and `req_priv` are held stable and known for the whole cycle in which `req_valid` is high. Several properties compare outputs against `$past` of these inputs. The bench drives every request field on the falling edge and holds it until the next falling edge, so each request is accepted at exactly one rising edge.

Before any checked read, the bench writes the location it will read. This keeps read data away from uninitialised memory contents. Before any write whose prior contents it checks, it has likewise written that location.

// File: rtl/desc_access_pkg.sv
package desc_access_pkg;
  localparam int WORD_W = 51;
  localparam int TAG_W  = 3;
  localparam int ADDR_W = 20;
  localparam int LEN_W  = 20;
  localparam int RSVD_W = WORD_W - TAG_W - 1 - LEN_W - ADDR_W;
  localparam int FLT_W  = 3;

  localparam logic [TAG_W-1:0] TAG_DATA_DESC = 3'b101;
  localparam logic [TAG_W-1:0] TAG_CTRL_WORD = 3'b011;

  localparam logic [FLT_W-1:0] FLT_NONE  = 3'b000;
  localparam logic [FLT_W-1:0] FLT_TYPE  = 3'b100;
  localparam logic [FLT_W-1:0] FLT_PRES  = 3'b010;
  localparam logic [FLT_W-1:0] FLT_INDEX = 3'b001;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic              resident;
    logic [RSVD_W-1:0] rsvd;
    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] base;
  } desc_t;
endpackage

// File: rtl/desc_check.sv
module desc_check
  import desc_access_pkg::*;
(
  input  desc_t              desc,
  input  logic [ADDR_W-1:0]  index,
  input  logic               write,
  input  logic [TAG_W-1:0]   wtag,
  input  logic               priv,
  output logic [FLT_W-1:0]   fault,
  output logic [ADDR_W-1:0]  phys
);
  logic type_bad, pres_bad, idx_bad;

  always_comb begin
    type_bad = (desc.tag != TAG_DATA_DESC) || (|desc.rsvd) ||
               (write && (wtag == TAG_CTRL_WORD) && !priv);
    pres_bad = !desc.resident;
    idx_bad  = (index > desc.len);
    if (type_bad)      fault = FLT_TYPE;
    else if (pres_bad) fault = FLT_PRES;
    else if (idx_bad)  fault = FLT_INDEX;
    else               fault = FLT_NONE;
    phys = desc.base + index;
  end
endmodule

// File: rtl/word_ram.sv
module word_ram #(
  parameter int AW = 10,
  parameter int DW = 51
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      rdata <= mem[addr];
      if (we) mem[addr] <= wdata;
    end
  end
endmodule

// File: rtl/desc_access_unit.sv
module desc_access_unit
  import desc_access_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_priv,
  input  logic [WORD_W-1:0] req_desc,
  input  logic [ADDR_W-1:0] req_index,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              done_valid,
  output logic [ADDR_W-1:0] done_addr,
  output logic [WORD_W-1:0] done_rdata,
  output logic              fault_valid,
  output logic [FLT_W-1:0]  fault_code
);
  logic [FLT_W-1:0]  fault_c;
  logic [ADDR_W-1:0] phys_c;
  logic              accept, mem_en;
  desc_t             desc_c;

  assign desc_c = desc_t'(req_desc);
  assign accept = req_valid && req_ready;
  assign mem_en = accept && (fault_c == FLT_NONE);

  desc_check chk_i (
    .desc  (desc_c),
    .index (req_index),
    .write (req_write),
    .wtag  (req_wdata[WORD_W-1 -: TAG_W]),
    .priv  (req_priv),
    .fault (fault_c),
    .phys  (phys_c)
  );

  word_ram #(.AW(MEM_AW), .DW(WORD_W)) ram_i (
    .clk   (clk),
    .en    (mem_en),
    .we    (req_write),
    .addr  (phys_c[MEM_AW-1:0]),
    .wdata (req_wdata),
    .rdata (done_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready   <= 1'b0;
      done_valid  <= 1'b0;
      fault_valid <= 1'b0;
      fault_code  <= FLT_NONE;
      done_addr   <= '0;
    end else begin
      req_ready   <= 1'b1;
      done_valid  <= mem_en;
      fault_valid <= accept && (fault_c != FLT_NONE);
      if (accept) begin
        fault_code <= fault_c;
        done_addr  <= phys_c;
      end
    end
  end

  // R1: ready is held off throughout reset
  assert_ready_reset_R1: assert property (@(posedge clk) rst |=> !req_ready && !done_valid && !fault_valid);

  // R2: one outcome per accepted request, none otherwise
  assert_outcome_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (done_valid != fault_valid));
  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !done_valid && !fault_valid);

  // R7: reported fault is one-hot
  assert_fault_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> $countones(fault_code) == 1);

  // R7: a presence fault implies the descriptor tag was acceptable
  assert_pres_prio_R7: assert property (@(posedge clk) disable iff (rst)
    (fault_valid && fault_code[1]) |-> $past(req_desc[WORD_W-1 -: TAG_W]) == TAG_DATA_DESC);

  // R5: a non-resident descriptor never completes
  assert_no_done_nonres_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && !req_desc[WORD_W-TAG_W-1]) |=> !done_valid);

  // R8: completion address is base plus index
  assert_addr_R8: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> done_addr == ADDR_W'($past(req_desc[ADDR_W-1:0]) + $past(req_index)));
endmodule

// File: tb/desc_access_unit_tb_top.sv
module desc_access_unit_tb_top;
  localparam int W = 51;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_write, req_priv;
  logic          req_ready;
  logic [W-1:0]  req_desc, req_wdata;
  logic [19:0]   req_index;
  logic          done_valid, fault_valid;
  logic [19:0]   done_addr;
  logic [W-1:0]  done_rdata;
  logic [2:0]    fault_code;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  desc_access_unit #(.MEM_AW(10)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_priv(req_priv), .req_desc(req_desc),
    .req_index(req_index), .req_wdata(req_wdata), .done_valid(done_valid),
    .done_addr(done_addr), .done_rdata(done_rdata), .fault_valid(fault_valid),
    .fault_code(fault_code)
  );

  function automatic logic [W-1:0] mk_desc(input logic [2:0] tag, input logic res,
                                           input logic [19:0] len, input logic [19:0] base);
    return {tag, res, 7'd0, len, base};
  endfunction

  function automatic logic [W-1:0] mk_word(input logic [2:0] tag, input logic [47:0] v);
    return {tag, v};
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // one request; outputs sampled at the next falling edge (one rising edge later)
  task automatic issue(input logic [W-1:0] d, input logic [19:0] idx, input logic wr,
                       input logic [W-1:0] wd, input logic pv);
    req_desc = d; req_index = idx; req_write = wr; req_wdata = wd; req_priv = pv;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_done(input string req, input logic [19:0] addr);
    check({req, " done_valid"}, 64'(done_valid), 64'd1);
    check({req, " fault_valid"}, 64'(fault_valid), 64'd0);
    check({req, " done_addr"}, 64'(done_addr), 64'(addr));
  endtask

  task automatic expect_fault(input string req, input logic [2:0] code);
    check({req, " fault_valid"}, 64'(fault_valid), 64'd1);
    check({req, " done_valid"}, 64'(done_valid), 64'd0);
    check({req, " fault_code"}, 64'(fault_code), 64'(code));
  endtask

  localparam logic [W-1:0] GOOD = {3'b101, 1'b1, 7'd0, 20'd50, 20'd100};

  task automatic t_reset();
    rst = 1'b1; req_valid = 0; req_write = 0; req_priv = 0;
    req_desc = '0; req_index = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 64'(req_ready), 64'd0);
    check("R1 done in reset", 64'(done_valid), 64'd0);
    check("R1 fault in reset", 64'(fault_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", 64'(req_ready), 64'd1);
  endtask

  task automatic t_rw();
    issue(GOOD, 20'd5, 1'b1, mk_word(3'b000, 48'hA1), 1'b0);
    expect_done("R8 write addr", 20'd105);
    issue(GOOD, 20'd5, 1'b0, '0, 1'b0);
    expect_done("R9 read", 20'd105);
    check("R9 read data", 64'(done_rdata), 64'(mk_word(3'b000, 48'hA1)));
    issue(GOOD, 20'd5, 1'b1, mk_word(3'b010, 48'hB2), 1'b0);
    check("R10 prior contents", 64'(done_rdata), 64'(mk_word(3'b000, 48'hA1)));
    @(negedge clk);
    check("R2 idle done", 64'(done_valid), 64'd0);
    check("R2 idle fault", 64'(fault_valid), 64'd0);
  endtask

  task automatic t_type();
    issue(mk_desc(3'b000, 1'b1, 20'd50, 20'd100), 20'd1, 1'b0, '0, 1'b0);
    expect_fault("R3 bad tag", 3'b100);
    issue(GOOD | (51'd1 << 42), 20'd1, 1'b0, '0, 1'b0);
    expect_fault("R3 reserved bit", 3'b100);
    issue(GOOD, 20'd7, 1'b1, mk_word(3'b000, 48'h77), 1'b0);
    issue(GOOD, 20'd7, 1'b1, mk_word(3'b011, 48'hC0), 1'b0);
    expect_fault("R4 ctrl store", 3'b100);
    issue(GOOD, 20'd7, 1'b0, '0, 1'b0);
    check("R11 type fault no write", 64'(done_rdata), 64'(mk_word(3'b000, 48'h77)));
    issue(GOOD, 20'd7, 1'b1, mk_word(3'b011, 48'hC0), 1'b1);
    expect_done("R4 priv store", 20'd107);
    issue(GOOD, 20'd7, 1'b0, '0, 1'b0);
    check("R4 priv stored", 64'(done_rdata), 64'(mk_word(3'b011, 48'hC0)));
  endtask

  task automatic t_pres();
    issue(GOOD, 20'd6, 1'b1, mk_word(3'b000, 48'h66), 1'b0);
    issue(mk_desc(3'b101, 1'b0, 20'd50, 20'd100), 20'd6, 1'b1, mk_word(3'b000, 48'hEE), 1'b0);
    expect_fault("R5 non-resident", 3'b010);
    issue(GOOD, 20'd6, 1'b0, '0, 1'b0);
    check("R11 presence no write", 64'(done_rdata), 64'(mk_word(3'b000, 48'h66)));
  endtask

  task automatic t_index();
    issue(GOOD, 20'd50, 1'b0, '0, 1'b0);
    expect_done("R6 index equals length", 20'd150);
    issue(mk_desc(3'b101, 1'b1, 20'd100, 20'd100), 20'd51, 1'b1, mk_word(3'b000, 48'h51), 1'b0);
    issue(GOOD, 20'd51, 1'b1, mk_word(3'b000, 48'hFF), 1'b0);
    expect_fault("R6 index over length", 3'b001);
    issue(mk_desc(3'b101, 1'b1, 20'd100, 20'd100), 20'd51, 1'b0, '0, 1'b0);
    check("R11 index no write", 64'(done_rdata), 64'(mk_word(3'b000, 48'h51)));
  endtask

  task automatic t_prio();
    issue(mk_desc(3'b001, 1'b0, 20'd2, 20'd0), 20'd9, 1'b0, '0, 1'b0);
    expect_fault("R7 type over all", 3'b100);
    issue(mk_desc(3'b101, 1'b0, 20'd2, 20'd0), 20'd9, 1'b0, '0, 1'b0);
    expect_fault("R7 presence over index", 3'b010);
  endtask

  task automatic t_wrap();
    issue(mk_desc(3'b101, 1'b1, 20'hFFFFF, 20'hFFFF0), 20'h20, 1'b1, mk_word(3'b000, 48'h3C), 1'b0);
    expect_done("R8 wrap addr", 20'h00010);
    issue(mk_desc(3'b101, 1'b1, 20'd100, 20'd0), 20'h10, 1'b0, '0, 1'b0);
    check("R9 wrapped data", 64'(done_rdata), 64'(mk_word(3'b000, 48'h3C)));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rw();
    t_type();
    t_pres();
    t_index();
    t_prio();
    t_wrap();
    finish_run();
  end
endmodule